// File: doc/BRIEF.md
# Clocked Bus Master with Slave Wait Stretching

This block turns single-word requests from a local client into read or write cycles on a parallel bus shared by slaves of mixed speed. Each bus cycle has two phases. In the first clock the address (and, for a write, the data) is driven with both strobes low so the lines can settle. In the next clock the read or write strobe goes high. A slave fast enough to answer in one clock leaves `bus_wait` low and the transfer ends at the next rising edge. A slower slave holds `bus_wait` high. The master then freezes every bus output until `bus_wait` drops, and it takes the response at the ordinary rising-edge sampling point.

The local side uses a ready/valid request port and a one-cycle response pulse. The response carries the read data and the number of stall cycles the slave inserted. Only one transfer is in flight at a time, and a new request is taken only after the current bus cycle has finished.

Top module: `wsb_master`

## Requirements
- R1: After reset `req_ready` is 1, `bus_rd`, `bus_wr` and `rsp_valid` are 0, and `rsp_waits` and `rsp_rdata` are 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the response cycle, and requests presented meanwhile are ignored.
- R3: In the cycle after acceptance, `bus_addr` (and `bus_wdata` for a write) show the request values with both strobes 0. The strobe rises one cycle later with the address unchanged.
- R4: `req_write`=1 selects `bus_wr` and `req_write`=0 selects `bus_rd`. The two strobes are never 1 together.
- R5: With `bus_wait` low while the strobe is high, the strobe lasts one cycle. `rsp_valid` is seen in the third cycle after the request is presented in a cycle with `req_ready`=1.
- R6: While a strobe is high and `bus_wait` is 1 at the rising edge, `bus_addr`, `bus_wdata` and the strobes keep their values in the next cycle.
- R7: Read data is taken from `bus_rdata` at the first rising edge with a strobe high and `bus_wait` 0. It appears on `rsp_rdata` with `rsp_valid` and is held until the next read completes. Writes leave `rsp_rdata` unchanged.
- R8: `rsp_waits` gives the number of rising edges in the last transfer at which the strobe was high and `bus_wait` was 1. The count saturates at 2^WAIT_W-1.
- R9: `bus_wait` has no effect while no strobe is high.
- R10: `rsp_valid` is a single-cycle pulse, given once per transfer and only in the cycle after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Master idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| rsp_valid | output | 1 | Transfer finished (one-cycle pulse) |
| rsp_rdata | output | DATA_W | Data from the last read |
| rsp_waits | output | WAIT_W | Stall cycles in the last transfer |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wait | input | 1 | Slave stall request |
| bus_rdata | input | DATA_W | Slave read data |

## Verification
Two events can share one cycle: the response pulse of a finished transfer and the acceptance of the next request. The bench holds `req_valid` high across back-to-back transfers, so each completion cycle also takes a new request. The behavioural model must then match both the response fields and the address phase that follows, with no gap cycle. A second overlap is a `bus_wait` level that is already high when the address phase ends. The bench toggles `bus_wait` during idle and address cycles, and the model, which ignores it there, still expects the strobe on time.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2
  } wsb_phase_t;
endpackage

// File: rtl/wsb_seq.sv
module wsb_seq
  import wsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       bus_wait,
  output wsb_phase_t phase,
  output logic       done
);
  wsb_phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (start)     phase_d = PH_ADDR;
      PH_ADDR:                phase_d = PH_STRB;
      PH_STRB: if (!bus_wait) phase_d = PH_IDLE;
      default:                phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
  assign done  = (phase_q == PH_STRB) && !bus_wait;

  // R9
  addr_to_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |=> (phase_q == PH_STRB));
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STRB && bus_wait) |=> (phase_q == PH_STRB));
endmodule

// File: rtl/wsb_wait_cnt.sv
module wsb_wait_cnt #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [WAIT_W-1:0] count
);
  localparam logic [WAIT_W-1:0] CNT_MAX = {WAIT_W{1'b1}};

  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = clr || (inc && (cnt_q != CNT_MAX));

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R8
  wait_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  // R8
  wait_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wsb_datapath.sv
module wsb_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [WAIT_W-1:0] wait_count,
  output logic              write_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] wdata_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [WAIT_W-1:0] rsp_waits
);
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              vld_q;
  logic [DATA_W-1:0] rdata_q;
  logic [WAIT_W-1:0] waits_q;
  logic              rd_cap_en;

  assign rd_cap_en = done && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_cap_en) rdata_q <= bus_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    waits_q <= '0;
    else if (done) waits_q <= wait_count;
  end

  assign write_sel = wr_q;
  assign addr_out  = addr_q;
  assign wdata_out = wdata_q;
  assign rsp_valid = vld_q;
  assign rsp_rdata = rdata_q;
  assign rsp_waits = waits_q;

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R7
  write_keeps_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_q) |=> $stable(rdata_q));
endmodule

// File: rtl/wsb_master.sv
module wsb_master
  import wsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [WAIT_W-1:0] rsp_waits,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              bus_wait,
  input  logic [DATA_W-1:0] bus_rdata
);
  wsb_phase_t        phase;
  logic              done;
  logic              start;
  logic              write_sel;
  logic              strobe_on;
  logic [WAIT_W-1:0] wait_count;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign strobe_on = (phase == PH_STRB);

  wsb_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bus_wait (bus_wait),
    .phase    (phase),
    .done     (done)
  );

  wsb_wait_cnt #(.WAIT_W(WAIT_W)) u_wcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (phase == PH_ADDR),
    .inc   (strobe_on && bus_wait),
    .count (wait_count)
  );

  wsb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .bus_rdata  (bus_rdata),
    .wait_count (wait_count),
    .write_sel  (write_sel),
    .addr_out   (bus_addr),
    .wdata_out  (bus_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_waits  (rsp_waits)
  );

  assign bus_rd = strobe_on && !write_sel;
  assign bus_wr = strobe_on &&  write_sel;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  // R6
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_wait) |=>
      ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_rd) && $stable(bus_wr)));
  // R3
  addr_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd || bus_wr) |-> $stable(bus_addr));
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/tb_wsb_master.sv
module tb_wsb_master;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 8;
  localparam int WMAX = (1 << WW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [WW-1:0] rsp_waits;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_rd, bus_wr;
  logic          bus_wait = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int checks = 0;
  int fails  = 0;

  // slave control
  int slave_waits = 0;
  int strobe_seen = 0;
  bit idle_noise  = 1'b0;
  bit noise_bit   = 1'b0;

  // behavioural reference
  bit            m_busy = 0;
  bit            m_strobe = 0;
  bit            m_write = 0;
  int            m_waits = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  bit            m_rsp = 0;
  logic [DW-1:0] m_rdata = '0;
  int            m_rwaits = 0;

  wsb_master #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_waits(rsp_waits),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wait(bus_wait), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] slave_word(input logic [AW-1:0] a);
    return DW'(a) ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_strobe = 0; m_rsp = 0; m_rdata = '0; m_rwaits = 0;
    end else begin
      m_rsp = 0;
      if (!m_busy) begin
        if (req_valid) begin
          m_busy = 1; m_strobe = 0; m_write = req_write;
          m_addr = req_addr; m_wdata = req_wdata; m_waits = 0;
        end
      end else if (!m_strobe) begin
        m_strobe = 1;
      end else if (bus_wait) begin
        if (m_waits < WMAX) m_waits++;
      end else begin
        m_busy = 0; m_strobe = 0; m_rsp = 1; m_rwaits = m_waits;
        if (!m_write) m_rdata = bus_rdata;
      end
    end
  end

  // compare every cycle, then the slave reacts to the settled outputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == !m_busy, "R2 req_ready", req_ready, !m_busy);
      chk(bus_rd == (m_strobe && !m_write), "R4 bus_rd", bus_rd, m_strobe && !m_write);
      chk(bus_wr == (m_strobe && m_write), "R4 bus_wr", bus_wr, m_strobe && m_write);
      chk(rsp_valid == m_rsp, "R10 rsp_valid", rsp_valid, m_rsp);
      if (m_busy) chk(bus_addr == m_addr, "R3/R6 bus_addr", bus_addr, m_addr);
      if (m_busy && m_write) chk(bus_wdata == m_wdata, "R3/R6 bus_wdata", bus_wdata, m_wdata);
      if (m_rsp) begin
        chk(rsp_rdata == m_rdata, "R7 rsp_rdata", rsp_rdata, m_rdata);
        chk(int'(rsp_waits) == m_rwaits, "R8 rsp_waits", rsp_waits, m_rwaits);
      end
    end
    noise_bit = ~noise_bit;
    if (bus_rd || bus_wr) begin
      bus_wait    = (strobe_seen < slave_waits);
      bus_rdata   = bus_wait ? 16'hDEAD : slave_word(bus_addr);
      strobe_seen++;
    end else begin
      strobe_seen = 0;
      bus_wait    = idle_noise ? noise_bit : 1'b0;
      bus_rdata   = 16'hBEEF;
    end
  end

  // presents a request at a negedge with req_ready high; returns negedges to response
  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input int nwait, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    slave_waits = nwait;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) begin
        req_valid = 0;
        req_addr  = ~a;
        req_write = ~wr;
      end
    end while (!rsp_valid && lat < 2000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(bus_rd == 1'b0 && bus_wr == 1'b0, "R1 strobes", {bus_rd, bus_wr}, 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(rsp_waits == '0 && rsp_rdata == '0, "R1 rsp fields", {rsp_waits, rsp_rdata}, 0);
    rst_n = 1'b1;

    // R5 zero-wait read and write
    xfer(0, 16'h1234, 16'h0, 0, lat);
    chk(lat == 3, "R5 read latency", lat, 3);
    chk(rsp_rdata == slave_word(16'h1234), "R7 read data", rsp_rdata, slave_word(16'h1234));
    xfer(1, 16'h00F0, 16'hC0DE, 0, lat);
    chk(lat == 3, "R5 write latency", lat, 3);
    chk(rsp_rdata == slave_word(16'h1234), "R7 write keeps rdata", rsp_rdata, slave_word(16'h1234));

    // R6 R7 R8 stalled transfers
    xfer(0, 16'hABCD, 16'h0, 1, lat);
    chk(lat == 4, "R8 one wait latency", lat, 4);
    chk(rsp_waits == 1, "R8 one wait", rsp_waits, 1);
    xfer(0, 16'h0777, 16'h0, 5, lat);
    chk(lat == 8 && rsp_waits == 5, "R8 five waits", {lat, 8'(rsp_waits)}, {32'd8, 8'd5});
    xfer(1, 16'h4444, 16'h9999, 3, lat);
    chk(rsp_waits == 3, "R8 write waits", rsp_waits, 3);

    // R8 saturation
    xfer(0, 16'h0101, 16'h0, 300, lat);
    chk(rsp_waits == WMAX, "R8 saturation", rsp_waits, WMAX);
    chk(rsp_rdata == slave_word(16'h0101), "R7 data after long stall", rsp_rdata, slave_word(16'h0101));

    // R9 wait toggling outside strobe phase
    idle_noise = 1'b1;
    xfer(0, 16'h2222, 16'h0, 0, lat);
    chk(lat == 3, "R9 noise ignored", lat, 3);
    xfer(1, 16'h3333, 16'h7777, 2, lat);
    chk(lat == 5, "R9 noise with waits", lat, 5);

    // R2 back-to-back: request held high, completion and acceptance share a cycle
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    slave_waits = 1;
    req_valid = 1; req_write = 0; req_addr = 16'h5555; req_wdata = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (rsp_valid) req_addr = req_addr + 16'h0011;
    end
    req_valid = 0;
    idle_noise = 1'b0;
    repeat (10) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule